// File: doc/BRIEF.md
# SPI Interrupt Status and Clear Unit

This unit gathers the four event sources of an SPI controller (transmit done, receive ready, receive overflow and transmit underrun) into sticky raw status bits. It then masks them with per-source enable bits held in a control word and drives one registered interrupt line. The datapath pulses `evt_i` for one clock for each event. Software reaches the unit through a small word-addressed register port. That port has a combinational read path and a single-cycle write strobe.

Each source bit is held in its own two-state machine, one instance per source. The states are `SRC_IDLE` and `SRC_PEND`. The transition `SRC_IDLE -> SRC_PEND` is taken on an event pulse. The transition `SRC_PEND -> SRC_IDLE` is taken on a clear write to that bit with no event in the same cycle. In every other case the state holds.

The interrupt line is driven by a second machine with the states `LINE_LOW` and `LINE_HIGH`. It moves `LINE_LOW -> LINE_HIGH` when any masked bit is set. It moves `LINE_HIGH -> LINE_LOW` when no masked bit is set. The output is therefore the OR of the masked bits, delayed by one clock.

The register map is as follows:

| Word address | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | clear | write one to clear |
| 2 | raw status | read only |
| 3 | masked status | read only |

Top module: `spi_irq_unit`

## Requirements
- R1: After reset, the raw status is 0, the masked status is 0, the control word reads 0 and `irq_o` is low.
- R2: Status bit 0 is transmit done, bit 1 is receive ready, bit 2 is receive overflow and bit 3 is transmit underrun. A pulse on `evt_i[k]` sets raw bit k at the next clock edge, whether or not the source is enabled. The bit stays set until it is cleared.
- R3: The control word at address 0 stores the whole written word and reads it back. Its bits 7:4 are the enables. Bit 4 enables source 1, bit 5 enables source 0, bit 6 enables source 2 and bit 7 enables source 3.
- R4: The masked status equals the raw status ANDed with the enables. A read of address 3 returns the masked status in bits 3:0, and a read of address 2 returns the raw status in bits 3:0. All higher bits of both reads are 0.
- R5: Writing to address 1 clears exactly the raw bits that are 1 in bits 3:0 of the written data. Written zeros, and higher data bits, change nothing.
- R6: When an event pulse and a clear of the same bit fall in one cycle, the bit ends up set.
- R7: `irq_o` rises one clock after the masked status becomes nonzero. It falls one clock after the masked status becomes zero.
- R8: Writes to address 2 or 3 change no state. A read of address 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 4 | One-cycle event pulses from the datapath, indexed by status bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| raw_o | output | 4 | Raw status bits |
| masked_o | output | 4 | Masked status bits |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach from the ports is an event pulse landing in the same cycle as a clear write of the same bit. The driver issues both in a single stimulus step, so the collision happens on exactly one edge, and then checks that the bit survives. A second hard case is the one-clock lag of the interrupt line when enables change under already-pending bits. To reach it, the scoreboard model computes the line from the state before each edge, and the control word is rewritten while raw bits are held.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int NSRC   = 4;
    localparam int EN_LSB = 4;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_CLR  = 2'd1,
        ADR_RAW  = 2'd2,
        ADR_MSK  = 2'd3
    } reg_adr_e;

    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_PEND = 1'b1
    } src_state_e;

    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_e;

    // The two lowest enable bits are swapped relative to the status bits.
    function automatic logic [NSRC-1:0] field_to_src(input logic [NSRC-1:0] f);
        return {f[3], f[2], f[0], f[1]};
    endfunction

endpackage

// File: rtl/spi_irq_src_fsm.sv
module spi_irq_src_fsm
    import spi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    src_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: if (set_i)           state_d = SRC_PEND;
            SRC_PEND: if (clr_i && !set_i) state_d = SRC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q == SRC_PEND);
    end

endmodule

// File: rtl/spi_irq_line.sv
module spi_irq_line
    import spi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_i,
    output logic irq_o
);

    line_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_LOW:  if (any_i)  state_d = LINE_HIGH;
            LINE_HIGH: if (!any_i) state_d = LINE_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == LINE_HIGH);
    end

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
    import spi_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [NSRC-1:0]   raw_i,
    input  logic [NSRC-1:0]   masked_i,
    output logic [NSRC-1:0]   en_src_o,
    output logic [NSRC-1:0]   clr_o,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int PAD_W = DATA_W - NSRC;

    logic [DATA_W-1:0] ctrl_q;
    logic              hit_ctrl, hit_clr, hit_raw, hit_msk;

    always_comb begin
        hit_ctrl = (reg_addr == ADDR_W'(ADR_CTRL));
        hit_clr  = (reg_addr == ADDR_W'(ADR_CLR));
        hit_raw  = (reg_addr == ADDR_W'(ADR_RAW));
        hit_msk  = (reg_addr == ADDR_W'(ADR_MSK));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ctrl_q <= '0;
        else if (reg_wr && hit_ctrl) ctrl_q <= reg_wdata;
    end

    always_comb begin
        en_src_o = field_to_src(ctrl_q[EN_LSB +: NSRC]);
        clr_o    = (reg_wr && hit_clr) ? reg_wdata[NSRC-1:0] : '0;
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_ctrl)     reg_rdata = ctrl_q;
        else if (hit_raw) reg_rdata = {{PAD_W{1'b0}}, raw_i};
        else if (hit_msk) reg_rdata = {{PAD_W{1'b0}}, masked_i};
    end

endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        evt_i,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [3:0]        raw_o,
    output logic [3:0]        masked_o,
    output logic              irq_o
);

    logic [NSRC-1:0] en_src;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] pend;

    spi_irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .raw_i     (pend),
        .masked_i  (masked_o),
        .en_src_o  (en_src),
        .clr_o     (clr_vec),
        .reg_rdata (reg_rdata)
    );

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        spi_irq_src_fsm u_src (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (evt_i[k]),
            .clr_i  (clr_vec[k]),
            .pend_o (pend[k])
        );
    end

    always_comb begin
        raw_o    = pend;
        masked_o = pend & en_src;
    end

    spi_irq_line u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .any_i (|masked_o),
        .irq_o (irq_o)
    );

endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
    import spi_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        evt_i,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [3:0]        raw_o,
    input logic [3:0]        masked_o,
    input logic              irq_o
);

    logic       clr_wr;
    logic [3:0] clr_bits;

    always_comb begin
        clr_wr   = reg_wr && (reg_addr == ADDR_W'(ADR_CLR));
        clr_bits = clr_wr ? reg_wdata[3:0] : 4'h0;
    end

    // R2
    ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != 4'h0) |=> ((raw_o & $past(evt_i)) == $past(evt_i)));

    // R5
    clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_o & ($past(raw_o) & ~$past(clr_bits))) == ($past(raw_o) & ~$past(clr_bits))));

    // R5
    clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((raw_o & ($past(clr_bits) & ~$past(evt_i))) == 4'h0));

    // R7
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == ($past(masked_o) != 4'h0)));

    // R3
    ctrl_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(ADR_CTRL))
        |=> (masked_o == (raw_o & field_to_src($past(reg_wdata[EN_LSB +: 4])))));

    // R8
    ro_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == ADDR_W'(ADR_RAW) || reg_addr == ADDR_W'(ADR_MSK)) && evt_i == 4'h0)
        |=> $stable(raw_o));

endmodule

bind spi_irq_unit spi_irq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .raw_o     (raw_o),
    .masked_o  (masked_o),
    .irq_o     (irq_o)
);

// File: tb/tb_spi_irq_unit.sv
module tb_spi_irq_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [3:0] raw;
        logic [3:0] msk;
        logic       irq;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  evt = '0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  raw, msk;
    logic        irq;

    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    logic [3:0]  raw_m = '0;
    logic [31:0] ctrl_m = '0;
    logic        irq_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_irq_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .reg_wr    (wr),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .raw_o     (raw),
        .masked_o  (msk),
        .irq_o     (irq)
    );

    function automatic logic [3:0] map_en(input logic [31:0] c);
        return {c[7], c[6], c[4], c[5]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic step(input logic [3:0] ev, input bit w, input logic [1:0] a,
                        input logic [31:0] d, input string tag);
        exp_t e;
        logic [3:0] clr;
        @(negedge clk);
        evt = ev; wr = w; addr = a; wdata = d;
        clr   = (w && a == 2'd1) ? d[3:0] : 4'h0;
        irq_m = |(raw_m & map_en(ctrl_m));
        raw_m = (raw_m & ~clr) | ev;
        if (w && a == 2'd0) ctrl_m = d;
        e.raw = raw_m;
        e.msk = raw_m & map_en(ctrl_m);
        e.irq = irq_m;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] expv, input string tag);
        step(4'h0, 1'b0, a, 32'h0, tag);
        #1;
        chk(rdata === expv, tag, rdata, expv);
    endtask

    // Monitor: compares results one time unit after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(raw === e.raw, {e.tag, " raw"}, 32'(raw), 32'(e.raw));
            chk(msk === e.msk, {e.tag, " masked"}, 32'(msk), 32'(e.msk));
            chk(irq === e.irq, {e.tag, " irq"}, 32'(irq), 32'(e.irq));
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(raw === 4'h0, "R1 raw", 32'(raw), 0);
        chk(msk === 4'h0, "R1 masked", 32'(msk), 0);
        chk(irq === 1'b0, "R1 irq", 32'(irq), 0);
        chk(rdata === 32'h0, "R1 ctrl", rdata, 0);
        rst_n = 1'b1;

        // R2: events set raw bits while every source is disabled
        step(4'b0001, 0, 2'd0, 0, "R2 tx done");
        step(4'b0110, 0, 2'd0, 0, "R2 rx ready+overflow");
        step(4'b0000, 0, 2'd0, 0, "R2 hold");
        rd_chk(2'd2, 32'h7, "R2 raw read");
        rd_chk(2'd3, 32'h0, "R4 masked read disabled");

        // R3: bit 4 enables source 1; R7: irq one cycle later
        step(4'h0, 1, 2'd0, 32'h0000_0010, "R3 enable rx ready");
        step(4'h0, 0, 2'd0, 0, "R7 irq rises");
        rd_chk(2'd0, 32'h0000_0010, "R3 ctrl readback");

        // R3/R4: every enable set, upper control bits read back
        step(4'h0, 1, 2'd0, 32'hA5A5_F0F0, "R3 all enables");
        rd_chk(2'd0, 32'hA5A5_F0F0, "R3 full word readback");
        rd_chk(2'd3, 32'h7, "R4 masked read");

        // R5: write one to clear a single bit, then clear of non-pending bit
        step(4'h0, 1, 2'd1, 32'h0000_0002, "R5 clear bit1");
        step(4'h0, 1, 2'd1, 32'hFFFF_FFF8, "R5 clear idle bit3");
        rd_chk(2'd2, 32'h5, "R5 raw after clears");

        // R6: event and clear collide on bit 0
        step(4'b0001, 1, 2'd1, 32'h0000_0001, "R6 set beats clear");
        step(4'h0, 0, 2'd0, 0, "R6 hold");

        // R8: writes to read-only addresses; clear address reads zero
        step(4'h0, 1, 2'd2, 32'h0, "R8 write raw addr");
        step(4'h0, 1, 2'd3, 32'h0, "R8 write masked addr");
        rd_chk(2'd1, 32'h0, "R8 clear addr reads zero");

        // R3: each enable position on its own
        step(4'b1000, 1, 2'd0, 32'h0000_0020, "R3 bit5 to source0");
        step(4'h0, 1, 2'd0, 32'h0000_0040, "R3 bit6 to source2");
        step(4'h0, 1, 2'd0, 32'h0000_0080, "R3 bit7 to source3");
        step(4'h0, 1, 2'd0, 32'h0000_0010, "R3 bit4 none pending");
        step(4'h0, 0, 2'd0, 0, "R7 irq falls");

        // R5/R7: clear everything with enables on
        step(4'h0, 1, 2'd0, 32'h0000_00F0, "R7 re-enable");
        step(4'h0, 1, 2'd1, 32'h0000_000F, "R5 clear all");
        step(4'h0, 0, 2'd0, 0, "R7 irq low after clear");
        step(4'h0, 0, 2'd0, 0, "R7 idle");

        @(posedge clk);
        #2;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule